// File: doc/BRIEF.md
# Gated Retriggerable Pulse Stretcher

This block turns a single qualified edge on one of two asynchronous trigger pins into an output pulse whose length is a whole number of clock cycles. One trigger pin is active-low and the other is active-high. Either a falling edge on the low-active pin or a rising edge on the high-active pin can start a cycle. The other pin acts as an enable for that edge, so the user can choose leading-edge or trailing-edge triggering. Both pins are synchronized before their edges are examined.

A trigger that is accepted while the pulse is already running reloads the count, which stretches the pulse. A train of triggers that arrives faster than the period therefore holds the output true indefinitely. After every accepted trigger there is a short recovery window, set per trigger in cycles, during which further triggers are discarded. An optional lock-out input makes the block ignore all triggers while its output is true. An active-low clear forces the output false in the same cycle and stops any new cycle from starting. The block drives a true output and its complement. It holds no data path, so every pin is a plain control or status line and there is no handshake or back-pressure. One instance serves one channel.

Top module: `pulse_stretch_ch`

## Requirements
- R1: A falling edge on `trig_n_i` while `trig_p_i` is high starts a cycle. `pulse_o` goes to 1 after the third rising clock edge that follows the input change (two synchronizer stages, then the load).
- R2: A rising edge on `trig_p_i` while `trig_n_i` is low starts a cycle in the same way. A rising edge on `trig_p_i` while `trig_n_i` is high does not start a cycle, and neither does a falling edge on `trig_p_i`.
- R3: `period_i` is sampled when a trigger is accepted, and `pulse_o` then stays 1 for `period_i`+1 clock cycles. A period of 0 gives a single-cycle pulse.
- R4: A trigger accepted while `pulse_o` is 1 reloads the count, so the pulse ends `period_i`+1 cycles after the last accepted load.
- R5: Triggers that repeat at an interval shorter than `period_i`+1 cycles keep `pulse_o` at 1 without a gap.
- R6: While `clr_n` is 0, `pulse_o` is 0 in that same cycle, with no glitch whatever the triggers do. The running count and the recovery window are cancelled, and triggers detected during that time start no cycle, even after `clr_n` returns to 1.
- R7: `holdoff_i` is sampled with each accepted trigger. A later trigger whose load point would fall j cycles after that accepted load is ignored when j <= `holdoff_i`, and is accepted when j > `holdoff_i`.
- R8: `pulse_no` is always the inverse of `pulse_o`.
- R9: While `lockout_i` is 1, triggers that arrive while `pulse_o` is 1 are ignored. Triggers that arrive while `pulse_o` is 0 still start a cycle.
- R10: While `rst_n` is 0 and after it is released, `pulse_o` is 0 and `pulse_no` is 1 until a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low overriding clear, synchronous to `clk` |
| trig_n_i | input | 1 | Asynchronous active-low trigger pin |
| trig_p_i | input | 1 | Asynchronous active-high trigger pin |
| period_i | input | CNT_W | Pulse length minus one, in cycles, sampled on accept |
| holdoff_i | input | CNT_W | Recovery window in cycles, sampled on accept |
| lockout_i | input | 1 | 1 = ignore triggers while the pulse is true |
| pulse_o | output | 1 | True output |
| pulse_no | output | 1 | Complement output |

## Verification
Some rules are checked on every cycle by the assertions. A low clear must keep the output low. After an accepted load, the recovery counter must hold exactly the sampled window. A zero count with no reload must end the pulse on the next edge. With lock-out on, a running count must keep falling by one. Every rise of the output must follow an accepted trigger. Other behaviour can only be shown by the bench's scenarios, because it depends on a sequence of input edges measured against an independent cycle count. This covers the polarity gating of the two pins, the exact pulse length and its extension, the boundary of the recovery window on both sides, and the fact that edges seen during a clear are lost.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_RUN  = 1'b1
  } ps_state_e;

  localparam int unsigned PS_SYNC_MIN = 2;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ps_edge_qual.sv
module ps_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_s_i,
  input  logic hi_s_i,
  output logic trig_o
);
  logic lo_prev;
  logic hi_prev;
  logic lo_fell;
  logic hi_rose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_prev <= 1'b0;
      hi_prev <= 1'b0;
    end else begin
      lo_prev <= lo_s_i;
      hi_prev <= hi_s_i;
    end
  end

  // Each edge is gated by the level of the other pin
  assign lo_fell = lo_prev & ~lo_s_i & hi_s_i;
  assign hi_rose = ~hi_prev & hi_s_i & ~lo_s_i;
  assign trig_o  = lo_fell | hi_rose;
endmodule

// File: rtl/ps_timer.sv
module ps_timer
  import ps_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] holdoff_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             hold_busy_o
);
  ps_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      cnt   <= '0;
      hold  <= '0;
    end else if (!clr_n) begin
      state <= PS_IDLE;
      cnt   <= '0;
      hold  <= '0;
    end else if (load_i) begin
      state <= PS_RUN;
      cnt   <= period_i;
      hold  <= holdoff_i;
    end else begin
      if (state == PS_RUN) begin
        if (cnt == '0) state <= PS_IDLE;
        else           cnt   <= cnt - 1'b1;
      end
      if (hold != '0) hold <= hold - 1'b1;
    end
  end

  assign active_o    = (state == PS_RUN);
  assign cnt_o       = cnt;
  assign hold_o      = hold;
  assign hold_busy_o = (hold != '0);
endmodule

// File: rtl/pulse_stretch_ch.sv
module pulse_stretch_ch
  import ps_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             trig_n_i,
  input  logic             trig_p_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             lockout_i,
  output logic             pulse_o,
  output logic             pulse_no
);
  localparam int unsigned SYNC_N = (SYNC_DEPTH < PS_SYNC_MIN) ? PS_SYNC_MIN : SYNC_DEPTH;

  logic             lo_s;
  logic             hi_s;
  logic             trig;
  logic             accept;
  logic             active;
  logic             hold_busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_cnt;

  ps_sync #(.STAGES(SYNC_N)) u_sync_lo (
    .clk(clk), .rst_n(rst_n), .d_i(trig_n_i), .q_o(lo_s)
  );

  ps_sync #(.STAGES(SYNC_N)) u_sync_hi (
    .clk(clk), .rst_n(rst_n), .d_i(trig_p_i), .q_o(hi_s)
  );

  ps_edge_qual u_qual (
    .clk(clk), .rst_n(rst_n), .lo_s_i(lo_s), .hi_s_i(hi_s), .trig_o(trig)
  );

  assign accept = trig & clr_n & ~hold_busy & ~(lockout_i & active);

  ps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .load_i     (accept),
    .period_i   (period_i),
    .holdoff_i  (holdoff_i),
    .active_o   (active),
    .cnt_o      (cnt),
    .hold_o     (hold_cnt),
    .hold_busy_o(hold_busy)
  );

  // The clear masks the registered state, so the output drops in the same cycle
  assign pulse_o  = active & clr_n;
  assign pulse_no = ~pulse_o;
endmodule

// File: rtl/pulse_stretch_ch_chk.sv
module pulse_stretch_ch_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             lockout_i,
  input logic [CNT_W-1:0] holdoff_i,
  input logic             pulse_o,
  input logic             accept,
  input logic             active,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold_cnt
);
  // R6
  a_r6_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !pulse_o);

  // R7
  a_r7_window_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (hold_cnt == $past(holdoff_i)));

  // R3
  a_r3_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == '0 && !accept) |=> !pulse_o);

  // R9
  a_r9_lockout_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_i && active && cnt != '0 && clr_n) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R1 and R2
  a_r1_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(accept));
endmodule

bind pulse_stretch_ch pulse_stretch_ch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .lockout_i(lockout_i),
  .holdoff_i(holdoff_i),
  .pulse_o  (pulse_o),
  .accept   (accept),
  .active   (active),
  .cnt      (cnt),
  .hold_cnt (hold_cnt)
);

// File: tb/pulse_stretch_ch_tb_top.sv
module pulse_stretch_ch_tb_top;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr_n = 1'b1;
  logic             trig_n = 1'b1;
  logic             trig_p = 1'b0;
  logic [CNT_W-1:0] period = 8'd6;
  logic [CNT_W-1:0] holdoff = 8'd1;
  logic             lockout = 1'b0;
  logic             pulse_o;
  logic             pulse_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_stretch_ch #(.CNT_W(CNT_W), .SYNC_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
    .trig_n_i(trig_n), .trig_p_i(trig_p),
    .period_i(period), .holdoff_i(holdoff), .lockout_i(lockout),
    .pulse_o(pulse_o), .pulse_no(pulse_no)
  );

  // {trig_n, trig_p, advance[3:0], expected pulse_o}; period 6, holdoff 1
  localparam logic [6:0] VEC [11] = '{
    {1'b1, 1'b0, 4'd3, 1'b0},  // idle
    {1'b1, 1'b1, 4'd3, 1'b0},  // R2 high pin rises with low pin high: no start
    {1'b0, 1'b1, 4'd3, 1'b1},  // R1 low pin falls while high pin high
    {1'b0, 1'b1, 4'd6, 1'b1},  // R3 last true cycle
    {1'b0, 1'b1, 4'd1, 1'b0},  // R3 ended after period+1
    {1'b0, 1'b0, 4'd3, 1'b0},  // R2 falling high pin: no start
    {1'b0, 1'b1, 4'd3, 1'b1},  // R2 rising high pin while low pin low
    {1'b0, 1'b0, 4'd2, 1'b1},
    {1'b0, 1'b1, 4'd3, 1'b1},  // R4 retrigger reloads
    {1'b0, 1'b1, 4'd6, 1'b1},  // R4 still true past first end
    {1'b0, 1'b1, 4'd1, 1'b0}   // R4 ends period+1 after reload
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    ticks(3);
    chk(pulse_o, 1'b0, "R10 pulse_o in reset");
    chk(pulse_no, 1'b1, "R10 pulse_no in reset");
    rst_n = 1'b1;
    ticks(4);
    chk(pulse_o, 1'b0, "R10 pulse_o after reset");

    // Table walk
    for (int v = 0; v < 11; v++) begin
      trig_n = VEC[v][6];
      trig_p = VEC[v][5];
      ticks(int'(VEC[v][4:1]));
      chk(pulse_o, VEC[v][0], $sformatf("R1/R2/R3/R4 vector %0d", v));
      chk(pulse_no, ~VEC[v][0], $sformatf("R8 vector %0d", v));
    end

    // R3 zero period gives one cycle
    period = 8'd0; holdoff = 8'd0;
    trig_p = 1'b0; ticks(5);
    trig_p = 1'b1; ticks(3);
    chk(pulse_o, 1'b1, "R3 zero period high");
    tick();
    chk(pulse_o, 1'b0, "R3 zero period one cycle");

    // R7 retrigger inside window is ignored (j = 4, window 4)
    period = 8'd20; holdoff = 8'd4;
    trig_p = 1'b0; ticks(5);
    trig_p = 1'b1; ticks(2);
    trig_p = 1'b0; ticks(2);
    trig_p = 1'b1; ticks(19);
    chk(pulse_o, 1'b1, "R7 blocked case last cycle");
    tick();
    chk(pulse_o, 1'b0, "R7 retrigger at window edge ignored");

    // R7 retrigger past window is accepted (j = 6)
    ticks(10);
    trig_p = 1'b0; ticks(5);
    trig_p = 1'b1; ticks(2);
    trig_p = 1'b0; ticks(4);
    trig_p = 1'b1; ticks(18);
    chk(pulse_o, 1'b1, "R7 retrigger past window accepted");
    ticks(5);
    chk(pulse_o, 1'b1, "R4 last cycle after reload");
    tick();
    chk(pulse_o, 1'b0, "R4 end after reload");

    // R9 lock-out
    period = 8'd5; holdoff = 8'd0; lockout = 1'b1;
    ticks(5);
    trig_p = 1'b0; ticks(5);
    trig_p = 1'b1; ticks(2);
    trig_p = 1'b0; ticks(2);
    trig_p = 1'b1; ticks(4);
    chk(pulse_o, 1'b1, "R9 pulse running");
    tick();
    chk(pulse_o, 1'b0, "R9 retrigger locked out");
    trig_p = 1'b0; ticks(3);
    trig_p = 1'b1; ticks(3);
    chk(pulse_o, 1'b1, "R9 idle trigger accepted");
    ticks(10);
    lockout = 1'b0;

    // R6 clear
    period = 8'd10;
    trig_p = 1'b0; ticks(5);
    trig_p = 1'b1; ticks(3);
    chk(pulse_o, 1'b1, "R6 pulse before clear");
    ticks(2);
    clr_n = 1'b0; #1;
    chk(pulse_o, 1'b0, "R6 clear drops output at once");
    chk(pulse_no, 1'b1, "R8 complement under clear");
    for (int i = 0; i < 20; i++) begin
      trig_p = ((i % 4) < 2);
      tick();
      chk(pulse_o, 1'b0, "R6 no glitch while cleared");
    end
    trig_p = 1'b0;
    ticks(5);
    clr_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(pulse_o, 1'b0, "R6 edges during clear lost");
    end
    trig_p = 1'b1; ticks(3);
    chk(pulse_o, 1'b1, "R6 trigger after release");
    ticks(15);

    // R5 continuous output under fast retriggers
    period = 8'd6;
    trig_p = 1'b0; ticks(5);
    for (int i = 0; i < 40; i++) begin
      trig_p = ((i % 4) < 2);
      tick();
      if (i >= 2) chk(pulse_o, 1'b1, "R5 continuous true");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule